// File: doc/BRIEF.md
# External Bus Byte-Mode Access Sequencer

This block sits between a 16-bit CPU data port and an external memory bus that can be strapped as 8 or 16 bits wide. Each CPU access arrives as a single request on a request/ready handshake. The block turns it into one or two external bus cycles, picks the byte lanes and byte enables for each cycle, and assembles read data into a 16-bit word before it signals ready.

A small 16-bit control register inside the block holds a two-bit lane-select field. The field chooses between full-word transfers, upper-byte-only transfers and lower-byte-only transfers. The same lane selection also governs CPU accesses to the control register itself. The mode and the bus width are captured when an access is accepted, so a change never affects an access that is already under way. The reserved mode value is handled like a word access, so the bus can never stall.

Top module: `extbus_byte_seq`

## Requirements
- R1: After reset the lane-select field is 0 (word mode), `cpu_rdy` and `ext_cyc` are low, and a control-register read returns 16'h0000.
- R2: The lane-select field is bits 1:0 of the control register, encoded 0 = word, 1 = upper byte only, 2 = lower byte only, 3 = reserved. Bits 15:2 always read as zero and ignore writes.
- R3: A control-register access in word mode reads and writes all 16 bits. In upper-byte mode a write leaves the field unchanged and a read returns 16'h0000. In lower-byte mode only bits 7:0 are written and bits 15:8 read as zero.
- R4: With `bus_wide`=1 in word mode, a CPU access makes exactly one bus cycle at byte address {addr,0} with `ext_be`=2'b11 and full 16-bit data.
- R5: With `bus_wide`=0 in word mode, a CPU access makes two back-to-back cycles, each with `ext_be`=2'b01 and data on lane 7:0. The first cycle carries the low byte at byte address {addr,0}. The second carries the high byte at {addr,1}. Read data returns as {second byte, first byte}.
- R6: With `bus_wide`=1 in a byte mode, one cycle is made at {addr,0}. Upper-byte mode uses `ext_be`=2'b10 with write data in bits 15:8 and bits 7:0 zero. Lower-byte mode uses `ext_be`=2'b01 with write data in bits 7:0 and bits 15:8 zero. The unselected byte of the returned read word is zero.
- R7: With `bus_wide`=0 in a byte mode, one cycle is made with `ext_be`=2'b01 on lane 7:0. Upper-byte mode uses byte address {addr,1} and carries CPU bits 15:8. Lower-byte mode uses {addr,0} and carries CPU bits 7:0. Read data lands in the selected half of the word, and the other half is zero.
- R8: `cpu_rdy` is a one-clock pulse. For a bus access it rises in the cycle after the acknowledge of the last bus cycle. For a control-register access it rises in the cycle after acceptance. `cpu_rdata` is zero except during a read's ready pulse.
- R9: While the field holds 3, bus and control-register accesses behave exactly as in word mode.
- R10: The mode and `bus_wide` are sampled when a request is accepted. A later change of either one does not alter the cycles of an access in progress.
- R11: While `ext_cyc` is high and `ext_ack` is low, `ext_we`, `ext_addr`, `ext_be` and `ext_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel_ctrl | input | 1 | 1 = access the control register instead of the bus |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with `cpu_rdy` |
| cpu_rdy | output | 1 | One-clock completion pulse |
| bus_wide | input | 1 | External bus width: 1 = 16-bit, 0 = 8-bit |
| ext_cyc | output | 1 | Bus cycle active |
| ext_we | output | 1 | Bus cycle is a write |
| ext_addr | output | AW+1 | Byte address |
| ext_be | output | 2 | Byte-lane enables, bit 1 = lane 15:8 |
| ext_wdata | output | 16 | Bus write data |
| ext_rdata | input | 16 | Bus read data |
| ext_ack | input | 1 | Ends the current bus cycle |

## Verification
The hardest situation to reach from the ports is a change of bus width in the middle of a split word access. The CPU cannot issue a second request while one is pending, so the only input that can move mid-access is the `bus_wide` strap. The bench starts a narrow word access with wait states on the acknowledge, flips `bus_wide` high between the two byte cycles, and expects the scoreboard to still see two 8-bit cycles with the correct assembled read word. Reaching the locked upper-byte mode, where control writes are ignored, needs a word-mode write of the field first; the bench then proves the write was ignored through the byte enables of the next bus cycle.

// File: rtl/extbus_byte_seq.sv
`timescale 1ns/1ps
module extbus_byte_seq #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_sel_ctrl,
  input  logic [AW-1:0] cpu_addr,
  input  logic [15:0]   cpu_wdata,
  output logic [15:0]   cpu_rdata,
  output logic          cpu_rdy,
  input  logic          bus_wide,
  output logic          ext_cyc,
  output logic          ext_we,
  output logic [AW:0]   ext_addr,
  output logic [1:0]    ext_be,
  output logic [15:0]   ext_wdata,
  input  logic [15:0]   ext_rdata,
  input  logic          ext_ack
);

  localparam logic [1:0] M_WORD = 2'd0;
  localparam logic [1:0] M_HI   = 2'd1;
  localparam logic [1:0] M_LO   = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_DONE} st_t;

  st_t           st;
  logic [1:0]    mode_q;
  logic [1:0]    op_mode;
  logic          op_wide, op_we, op_reg, phase;
  logic [AW-1:0] op_addr;
  logic [15:0]   op_wdata, rdata_q;
  logic [7:0]    lo_q;

  logic [1:0]  cur_mode;
  logic [15:0] ctrl_rd, bus_rd;
  logic        odd, last;

  assign cur_mode = (mode_q == 2'd3) ? M_WORD : mode_q;

  always_comb begin
    case (cur_mode)
      M_HI:    ctrl_rd = 16'h0000;
      M_LO:    ctrl_rd = {14'd0, mode_q};
      default: ctrl_rd = {14'd0, mode_q};
    endcase
  end

  assign odd  = !op_wide && ((op_mode == M_WORD && phase) || op_mode == M_HI);
  assign last = op_wide || op_mode != M_WORD || phase;

  assign ext_cyc  = (st == S_BUS);
  assign ext_we   = ext_cyc && op_we;
  assign ext_addr = {op_addr, odd};

  always_comb begin
    if (op_wide) begin
      case (op_mode)
        M_HI:    begin ext_be = 2'b10; ext_wdata = {op_wdata[15:8], 8'h00}; end
        M_LO:    begin ext_be = 2'b01; ext_wdata = {8'h00, op_wdata[7:0]}; end
        default: begin ext_be = 2'b11; ext_wdata = op_wdata; end
      endcase
    end else begin
      ext_be    = 2'b01;
      ext_wdata = {8'h00, odd ? op_wdata[15:8] : op_wdata[7:0]};
    end
  end

  always_comb begin
    if (op_wide) begin
      case (op_mode)
        M_HI:    bus_rd = {ext_rdata[15:8], 8'h00};
        M_LO:    bus_rd = {8'h00, ext_rdata[7:0]};
        default: bus_rd = ext_rdata;
      endcase
    end else begin
      case (op_mode)
        M_HI:    bus_rd = {ext_rdata[7:0], 8'h00};
        M_LO:    bus_rd = {8'h00, ext_rdata[7:0]};
        default: bus_rd = {ext_rdata[7:0], lo_q};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= M_WORD;
      op_mode  <= M_WORD;
      op_wide  <= 1'b0;
      op_we    <= 1'b0;
      op_reg   <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      phase    <= 1'b0;
      lo_q     <= '0;
      rdata_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          op_mode  <= cur_mode;
          op_wide  <= bus_wide;
          op_we    <= cpu_we;
          op_reg   <= cpu_sel_ctrl;
          op_addr  <= cpu_addr;
          op_wdata <= cpu_wdata;
          phase    <= 1'b0;
          if (cpu_sel_ctrl) begin
            rdata_q <= cpu_we ? 16'h0000 : ctrl_rd;
            if (cpu_we && cur_mode != M_HI) mode_q <= cpu_wdata[1:0];
            st <= S_DONE;
          end else begin
            st <= S_BUS;
          end
        end
        S_BUS: if (ext_ack) begin
          if (last) begin
            rdata_q <= op_we ? 16'h0000 : bus_rd;
            st      <= S_DONE;
          end else begin
            lo_q  <= ext_rdata[7:0];
            phase <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_rdy   = (st == S_DONE);
  assign cpu_rdata = cpu_rdy ? rdata_q : 16'h0000;

endmodule

module extbus_byte_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_rdy,
  input logic [15:0] cpu_rdata,
  input logic        ext_cyc,
  input logic        ext_we,
  input logic [1:0]  ext_be,
  input logic [15:0] ext_wdata,
  input logic        ext_ack,
  input logic        op_reg
);
  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |=> !cpu_rdy); // R8
  AST_RDY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy && !op_reg |-> $past(ext_ack)); // R8
  AST_RDY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |-> !ext_cyc); // R8
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy && op_reg |-> cpu_rdata[15:2] == 14'd0); // R2
  AST_LO_LANE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc && ext_be == 2'b01 |-> ext_wdata[15:8] == 8'h00); // R6
  AST_HI_LANE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc && ext_be == 2'b10 |-> ext_wdata[7:0] == 8'h00); // R6
  AST_CYC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc && !ext_ack |=> ext_cyc && $stable(ext_be) && $stable(ext_we) && $stable(ext_wdata)); // R11
endmodule

bind extbus_byte_seq extbus_byte_seq_chk u_chk (.*);

// File: tb/extbus_byte_seq_bench.sv
`timescale 1ns/1ps
module extbus_byte_seq_bench;
  localparam int AW = 15;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, cpu_sel_ctrl = 0, bus_wide = 1;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_rdy, ext_cyc, ext_we, ext_ack;
  logic [AW:0] ext_addr;
  logic [1:0] ext_be;
  logic [15:0] ext_wdata, ext_rdata;

  always #5 clk = ~clk;

  extbus_byte_seq #(.AW(AW)) u_extbus_byte_seq (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_sel_ctrl(cpu_sel_ctrl), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy), .bus_wide(bus_wide),
    .ext_cyc(ext_cyc), .ext_we(ext_we), .ext_addr(ext_addr), .ext_be(ext_be),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack));

  int errors = 0, checks = 0;
  int wait_n = 0, cnt = 0;
  logic [1:0] mdl_mode = 2'd0;

  typedef struct packed {
    logic        we;
    logic [AW:0] addr;
    logic [1:0]  be;
    logic [15:0] wd;
  } cyc_t;
  cyc_t  exp_q[$];
  string tag_q[$];

  function automatic logic [15:0] pat(input logic [AW:0] ba);
    return (16'(ba) * 16'h2B3D) ^ 16'hC35A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  assign ext_rdata = pat(ext_addr);

  always @(posedge clk) begin
    if (!rst_n) begin ext_ack <= 0; cnt <= 0; end
    else if (ext_cyc && !ext_ack) begin
      if (cnt >= wait_n) begin ext_ack <= 1; cnt <= 0; end
      else cnt <= cnt + 1;
    end else ext_ack <= 0;
  end

  // monitor: scoreboard side
  logic pv_cyc = 0, pv_ack = 0, pv_we = 0;
  logic [AW:0] pv_addr = '0;
  logic [1:0] pv_be = '0;
  logic [15:0] pv_wd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ext_cyc && pv_cyc && !pv_ack)
        chk({ext_we, ext_addr, ext_be, ext_wdata} == {pv_we, pv_addr, pv_be, pv_wd}, "R11 held",
            32'({ext_addr, ext_be}), 32'({pv_addr, pv_be}));
      if (ext_cyc && ext_ack) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected bus cycle", 32'(ext_addr), 0);
        else begin
          cyc_t e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(ext_we == e.we && ext_addr == e.addr && ext_be == e.be && (!e.we || ext_wdata == e.wd),
              t, {ext_we, ext_addr[12:0], ext_be, ext_wdata}, {e.we, e.addr[12:0], e.be, e.wd});
        end
      end
    end
    pv_cyc = ext_cyc; pv_ack = ext_ack; pv_we = ext_we;
    pv_addr = ext_addr; pv_be = ext_be; pv_wd = ext_wdata;
  end

  task automatic push(input logic we, input logic [AW:0] a, input logic [1:0] be, input logic [15:0] wd, input string t);
    cyc_t c;
    c.we = we; c.addr = a; c.be = be; c.wd = wd;
    exp_q.push_back(c); tag_q.push_back(t);
  endtask

  task automatic handshake(input string t, input logic [15:0] exp_rd, input bit is_reg, input bit flip);
    int n = 0;
    @(negedge clk);
    cpu_req = 1;
    @(negedge clk);
    cpu_req = 0;
    while (!cpu_rdy && n < 2000) begin
      @(negedge clk); n++;
      if (flip && n == 1) bus_wide = ~bus_wide;
    end
    chk(cpu_rdy, {t, " ready"}, 32'(cpu_rdy), 1);
    if (is_reg) chk(n == 0, "R8 ctrl ready latency", n, 0);
    else chk(exp_q.size() == 0, "R8 ready after last ack", exp_q.size(), 0);
    chk(cpu_rdata == exp_rd, {t, " rdata"}, 32'(cpu_rdata), 32'(exp_rd));
    @(negedge clk);
    chk(!cpu_rdy && cpu_rdata == 0, "R8 single pulse", {cpu_rdy, cpu_rdata}, 0);
  endtask

  task automatic bus_acc(input logic we, input logic [AW-1:0] a, input logic [15:0] d, input string t, input bit flip = 0);
    logic [1:0] m; logic [AW:0] b; logic [15:0] p0, p1, er;
    m  = (mdl_mode == 2'd3) ? 2'd0 : mdl_mode;
    b  = {a, 1'b0};
    p0 = pat(b); p1 = pat(b + 1);
    if (bus_wide) begin
      case (m)
        2'd1:    begin push(we, b, 2'b10, {d[15:8], 8'h00}, t); er = {p0[15:8], 8'h00}; end
        2'd2:    begin push(we, b, 2'b01, {8'h00, d[7:0]}, t); er = {8'h00, p0[7:0]}; end
        default: begin push(we, b, 2'b11, d, t); er = p0; end
      endcase
    end else begin
      case (m)
        2'd1:    begin push(we, b + 1, 2'b01, {8'h00, d[15:8]}, t); er = {p1[7:0], 8'h00}; end
        2'd2:    begin push(we, b, 2'b01, {8'h00, d[7:0]}, t); er = {8'h00, p0[7:0]}; end
        default: begin
          push(we, b, 2'b01, {8'h00, d[7:0]}, t);
          push(we, b + 1, 2'b01, {8'h00, d[15:8]}, t);
          er = {p1[7:0], p0[7:0]};
        end
      endcase
    end
    cpu_sel_ctrl = 0; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    handshake(t, we ? 16'h0000 : er, 0, flip);
  endtask

  task automatic ctrl_acc(input logic we, input logic [15:0] d, input string t);
    logic [1:0] m; logic [15:0] er;
    m  = (mdl_mode == 2'd3) ? 2'd0 : mdl_mode;
    er = (m == 2'd1) ? 16'h0000 : {14'd0, mdl_mode};
    if (we) begin
      er = 16'h0000;
      if (m != 2'd1) mdl_mode = d[1:0];
    end
    cpu_sel_ctrl = 1; cpu_we = we; cpu_wdata = d;
    handshake(t, er, 1, 0);
    cpu_sel_ctrl = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; cpu_req = 0; mdl_mode = 0;
    repeat (3) @(negedge clk);
    chk(!cpu_rdy && !ext_cyc, "R1 outputs idle in reset", {cpu_rdy, ext_cyc}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!cpu_rdy && !ext_cyc && cpu_rdata == 0, "R1 outputs idle after reset", {cpu_rdy, ext_cyc, cpu_rdata}, 0);
  endtask

  initial begin
    #1ms;
    chk(0, "R8 watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    ctrl_acc(0, 0, "R1 ctrl reset value");
    // R4 wide word
    bus_wide = 1; wait_n = 0;
    bus_acc(1, 15'h0012, 16'hBEEF, "R4 wide word write");
    bus_acc(0, 15'h0012, 0, "R4 wide word read");
    wait_n = 2;
    bus_acc(0, 15'h7FFF, 0, "R4 wide word read top addr");
    // R5 narrow split
    bus_wide = 0;
    bus_acc(1, 15'h0100, 16'h1234, "R5 narrow word write");
    wait_n = 0;
    bus_acc(0, 15'h0101, 0, "R5 narrow word read");
    bus_acc(0, 15'h7FFF, 0, "R5 narrow word read top addr");
    // R10 width flip mid split
    wait_n = 3;
    bus_acc(0, 15'h0033, 0, "R10 width change mid split", 1);
    bus_wide = 0; wait_n = 1;
    // R2 R3: reserved bits ignored, move to low-byte mode
    ctrl_acc(1, 16'hFFFE, "R2 word write of field");
    ctrl_acc(0, 0, "R3 low mode ctrl read");
    bus_acc(1, 15'h0040, 16'hA1B2, "R7 narrow low write");
    bus_acc(0, 15'h0041, 0, "R7 narrow low read");
    bus_wide = 1;
    bus_acc(1, 15'h0042, 16'hC3D4, "R6 wide low write");
    bus_acc(0, 15'h0043, 0, "R6 wide low read");
    // low-byte ctrl write reaching reserved value 3
    ctrl_acc(1, 16'h5A03, "R3 low mode ctrl write");
    ctrl_acc(0, 0, "R9 reserved mode ctrl read");
    bus_acc(1, 15'h0050, 16'h7788, "R9 wide word in mode3");
    bus_wide = 0;
    bus_acc(0, 15'h0051, 0, "R9 narrow word in mode3");
    // to upper-byte mode
    ctrl_acc(1, 16'h0001, "R9 word write in mode3");
    ctrl_acc(0, 0, "R3 high mode ctrl read zero");
    ctrl_acc(1, 16'h0000, "R3 high mode ctrl write ignored");
    bus_wide = 1;
    bus_acc(1, 15'h0060, 16'h9ABC, "R3 R6 wide high write");
    bus_acc(0, 15'h0061, 0, "R6 wide high read");
    bus_wide = 0; wait_n = 0;
    bus_acc(1, 15'h0062, 16'hDEF0, "R7 narrow high write");
    bus_acc(0, 15'h0063, 0, "R7 narrow high read");
    // reset restores word mode
    do_reset();
    ctrl_acc(0, 0, "R1 ctrl after second reset");
    bus_wide = 1;
    bus_acc(0, 15'h0070, 0, "R1 word mode after reset");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 no stray cycles", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule